// File: doc/BRIEF.md
# Two-Line Bit-Stream Character Receiver

This block recovers bytes from a serial link that uses two single-bit wires per direction. In every bit slot one wire is high: a high on the "one" wire carries a 1, and a high on the "zero" wire carries a 0. A slot in which both wires are low marks the end of a character. A character uses ten slots of equal length. The first eight carry data with the least significant bit first. The ninth carries the XOR of the eight data bits. The tenth is the empty end slot. When more data is waiting, the next character starts straight after the empty slot.

Both wires first pass through a two-flop synchronizer. After reset the receiver hunts for a quiet stretch, meaning both wires low for at least half a slot. It then arms on the next rising activity and times every later slot from that edge, sampling each slot once at its midpoint. Each finished character yields the byte with a one-cycle valid strobe and a parity-mismatch flag. A malformed slot gives a one-cycle framing-error strobe and sends the receiver back to hunting. The slot length is a parameter in clock cycles. At 27 MHz a thirtieth of a second gives 900000 cycles.

Top module: `tworail_char_rx`

## Requirements
- R1: While reset is high and in the cycle after it is released, `rx_vld`, `rx_frm_err`, `rx_par_err` and `rx_byte` are all zero.
- R2: A slot with `line_one`=1, `line_zero`=0 decodes as bit value 1. A slot with `line_one`=0, `line_zero`=1 decodes as bit value 0. The first data slot lands in `rx_byte[0]` and the eighth in `rx_byte[7]`.
- R3: The ninth slot is the parity bit. `rx_par_err` is 1 together with `rx_vld` exactly when that bit differs from the XOR of the eight received data bits. A character with a parity mismatch is still delivered.
- R4: The tenth slot must have both lines low. If either line is high at its sample point, `rx_frm_err` pulses and no `rx_vld` is produced for that character.
- R5: Characters sent back to back, with no idle time after the empty slot, are each decoded, in the order they were sent.
- R6: After reset or after a framing error, no character is accepted until both lines have been low for at least BIT_CYCLES/2 consecutive cycles. A shorter low stretch is ignored.
- R7: A data or parity slot whose sample shows both lines high or both lines low raises `rx_frm_err` for one cycle and produces no `rx_vld`. The receiver then resynchronises on the next qualifying gap and decodes the character that follows it.
- R8: Each slot is sampled BIT_CYCLES/2 cycles after the start of that slot as seen past the synchronizer. So `rx_vld` rises during the empty slot, between BIT_CYCLES/2 and BIT_CYCLES/2+4 cycles after that slot starts at the pins.
- R9: `rx_vld` and `rx_frm_err` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_one | input | 1 | Wire that is high in a slot carrying a 1 |
| line_zero | input | 1 | Wire that is high in a slot carrying a 0 |
| rx_byte | output | DATA_BITS | Last decoded byte |
| rx_vld | output | 1 | One-cycle strobe: `rx_byte` holds a new character |
| rx_par_err | output | 1 | Parity mismatch, valid while `rx_vld` is high |
| rx_frm_err | output | 1 | One-cycle strobe on a malformed slot |

## Verification
The bench builds the receiver with a 16-cycle slot, so the quiet threshold and the sample point are both 8 cycles. At that size a full character takes 160 cycles, which puts back-to-back streams, deliberately short gaps, and resynchronisation after every kind of bad slot within a few thousand cycles. The short slot also makes the position of the valid strobe inside the empty slot measurable to a single cycle against the R8 window.

// File: rtl/tworail_pkg.sv
package tworail_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RECV  = 2'd2
  } rx_state_t;
endpackage

// File: rtl/tworail_sync.sv
module tworail_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tworail_gap_watch.sv
module tworail_gap_watch #(
  parameter int QUIET_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic quiet,
  output logic gap_ok
);
  localparam int QW = $clog2(QUIET_CYCLES + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUIET_CYCLES);

  logic [QW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || !enable || !quiet) run_len <= '0;
    else if (run_len != QMAX)     run_len <= run_len + 1'b1;
  end

  assign gap_ok = enable && (run_len == QMAX);

  assert_arm_after_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(gap_ok) |-> $past(quiet));
endmodule

// File: rtl/tworail_slot_timer.sv
module tworail_slot_timer #(
  parameter int BIT_CYCLES = 900000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic sample
);
  localparam int CW = $clog2(BIT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] MID  = CW'(BIT_CYCLES / 2);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)        phase <= '0;
    else if (start) phase <= CW'(1);
    else if (run)   phase <= (phase == LAST) ? '0 : phase + 1'b1;
    else            phase <= '0;
  end

  assign sample = run && (phase == MID);

  assert_phase_range_R8: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);
endmodule

// File: rtl/tworail_char_rx.sv
module tworail_char_rx
  import tworail_pkg::*;
#(
  parameter int BIT_CYCLES = 900000,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_one,
  input  logic                 line_zero,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_vld,
  output logic                 rx_par_err,
  output logic                 rx_frm_err
);
  localparam int SLOTS = DATA_BITS + 2;
  localparam int SW    = $clog2(SLOTS);
  localparam logic [SW-1:0] GAP_SLOT = SW'(DATA_BITS + 1);

  logic [1:0] raw_lines, syn_lines;
  logic s_one, s_zero, active, quiet;
  logic gap_ok, sample_now;
  rx_state_t state;
  logic [SW-1:0] slot_idx;
  logic [DATA_BITS:0] shreg;

  assign raw_lines = {line_one, line_zero};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    tworail_sync #(.STAGES(2)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(syn_lines[g])
    );
  end

  assign s_one  = syn_lines[1];
  assign s_zero = syn_lines[0];
  assign active = s_one | s_zero;
  assign quiet  = !active;

  tworail_gap_watch #(.QUIET_CYCLES(BIT_CYCLES / 2)) u_gap (
    .clk   (clk),
    .rst   (rst),
    .enable(state == ST_HUNT),
    .quiet (quiet),
    .gap_ok(gap_ok)
  );

  tworail_slot_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (state == ST_ARMED && active),
    .run   (state == ST_RECV),
    .sample(sample_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HUNT;
      slot_idx   <= '0;
      shreg      <= '0;
      rx_byte    <= '0;
      rx_vld     <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
    end else begin
      rx_vld     <= 1'b0;
      rx_frm_err <= 1'b0;
      case (state)
        ST_HUNT: if (gap_ok) state <= ST_ARMED;
        ST_ARMED: begin
          if (active) begin
            state    <= ST_RECV;
            slot_idx <= '0;
          end
        end
        ST_RECV: begin
          if (sample_now) begin
            if (slot_idx != GAP_SLOT) begin
              if (s_one ^ s_zero) begin
                shreg    <= {s_one, shreg[DATA_BITS:1]};
                slot_idx <= slot_idx + 1'b1;
              end else begin
                rx_frm_err <= 1'b1;
                state      <= ST_HUNT;
              end
            end else if (quiet) begin
              rx_byte    <= shreg[DATA_BITS-1:0];
              rx_par_err <= shreg[DATA_BITS] ^ (^shreg[DATA_BITS-1:0]);
              rx_vld     <= 1'b1;
              state      <= ST_ARMED;
            end else begin
              rx_frm_err <= 1'b1;
              state      <= ST_HUNT;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  assert_vld_single_R9: assert property (@(posedge clk) disable iff (rst)
    rx_vld |=> !rx_vld);
  assert_vld_frm_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(rx_vld && rx_frm_err));
  assert_frm_to_hunt_R7: assert property (@(posedge clk) disable iff (rst)
    rx_frm_err |-> state == ST_HUNT);
  assert_vld_rearms_R5: assert property (@(posedge clk) disable iff (rst)
    rx_vld |-> state == ST_ARMED);
endmodule

// File: tb/sim_tworail_char_rx.sv
module sim_tworail_char_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BIT = 16;
  localparam int HALF = BIT / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_one = 1'b0;
  logic line_zero = 1'b0;
  logic [7:0] rx_byte;
  logic rx_vld, rx_par_err, rx_frm_err;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int vld_cnt = 0, frm_cnt = 0, vld_at = 0, gap_start = 0;
  logic [7:0] bytes_seen [0:7];
  logic perr_seen [0:7];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tworail_char_rx #(.BIT_CYCLES(BIT), .DATA_BITS(8)) u0 (
    .clk(clk), .rst(rst), .line_one(line_one), .line_zero(line_zero),
    .rx_byte(rx_byte), .rx_vld(rx_vld), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_vld) begin
        if (vld_cnt < 8) begin
          bytes_seen[vld_cnt] = rx_byte;
          perr_seen[vld_cnt] = rx_par_err;
        end
        vld_cnt = vld_cnt + 1;
        vld_at = cyc;
      end
      if (rx_frm_err) frm_cnt = frm_cnt + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    vld_cnt = 0;
    frm_cnt = 0;
  endtask

  task automatic slot(logic o, logic z);
    line_one = o;
    line_zero = z;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_char(logic [7:0] b, bit bad_par, bit bad_gap);
    for (int i = 0; i < 8; i++) slot(b[i], ~b[i]);
    slot((^b) ^ bad_par, ~((^b) ^ bad_par));
    gap_start = cyc;
    if (bad_gap) slot(1'b1, 1'b0);
    else         slot(1'b0, 1'b0);
  endtask

  task automatic t_reset();
    line_one = 1'b1; line_zero = 1'b0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 vld in reset", rx_vld, 0);
    check("R1 frm in reset", rx_frm_err, 0);
    check("R1 byte/perr in reset", {rx_byte, rx_par_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outputs after release", {rx_byte, rx_vld, rx_par_err, rx_frm_err}, 0);
  endtask

  task automatic t_short_gap();
    clear_mon();
    line_one = 1'b0; line_zero = 1'b0;
    repeat (3) @(negedge clk);
    send_char(8'h81, 0, 0);
    send_char(8'h6E, 0, 0);
    check("R6 short gap ignored, count", vld_cnt, 1);
    check("R6 decoded after real gap", bytes_seen[0], 8'h6E);
    check("R6 no framing error", frm_cnt, 0);
  endtask

  task automatic t_basic();
    clear_mon();
    slot(0, 0);
    send_char(8'hA5, 0, 0);
    check("R2 one valid", vld_cnt, 1);
    check("R2 byte A5", bytes_seen[0], 8'hA5);
    check("R3 parity ok", perr_seen[0], 0);
    check("R8 valid in gap slot", ((vld_at - gap_start) >= HALF) && ((vld_at - gap_start) <= HALF + 4), 1);
    clear_mon();
    send_char(8'h01, 0, 0);
    check("R2 lsb first 01", bytes_seen[0], 8'h01);
  endtask

  task automatic t_stream();
    clear_mon();
    send_char(8'h3C, 0, 0);
    send_char(8'hFF, 0, 0);
    send_char(8'h00, 0, 0);
    check("R5 three chars", vld_cnt, 3);
    check("R5 first", bytes_seen[0], 8'h3C);
    check("R5 second", bytes_seen[1], 8'hFF);
    check("R5 third", bytes_seen[2], 8'h00);
    check("R9 no framing error in stream", frm_cnt, 0);
  endtask

  task automatic t_parity();
    clear_mon();
    send_char(8'h5A, 1, 0);
    check("R3 delivered", vld_cnt, 1);
    check("R3 byte", bytes_seen[0], 8'h5A);
    check("R3 parity flagged", perr_seen[0], 1);
    clear_mon();
    send_char(8'h07, 0, 0);
    check("R3 parity clear again", perr_seen[0], 0);
  endtask

  task automatic t_both_high();
    clear_mon();
    for (int i = 0; i < 3; i++) slot(1, 0);
    slot(1, 1);
    for (int i = 0; i < 5; i++) slot(0, 1);
    slot(0, 0);
    send_char(8'hC3, 0, 0);
    check("R7 both-high one frame error", frm_cnt, 1);
    check("R7 resync count", vld_cnt, 1);
    check("R7 resync byte", bytes_seen[0], 8'hC3);
  endtask

  task automatic t_both_low();
    clear_mon();
    slot(1, 0);
    slot(0, 0);
    for (int i = 0; i < 7; i++) slot(0, 1);
    slot(0, 0);
    send_char(8'h9D, 0, 0);
    check("R7 both-low frame error", frm_cnt, 1);
    check("R7 both-low resync count", vld_cnt, 1);
    check("R7 both-low resync byte", bytes_seen[0], 8'h9D);
  endtask

  task automatic t_bad_gap();
    clear_mon();
    send_char(8'h42, 0, 1);
    check("R4 missing gap frame error", frm_cnt, 1);
    check("R4 no valid", vld_cnt, 0);
    slot(0, 0);
    send_char(8'hE1, 0, 0);
    check("R4 recover byte", bytes_seen[0], 8'hE1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_short_gap();
    t_basic();
    t_stream();
    t_parity();
    t_both_high();
    t_both_low();
    t_bad_gap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule